// File: doc/BRIEF.md
# CAN Base-Format Data Frame Sender

This block puts one CAN data frame with an 11-bit identifier onto the bus each time it is asked to, and then says how the attempt ended. The caller supplies the identifier, up to eight payload bytes packed into a 64-bit word, a byte count and the length of one bit in clock cycles, then pulses `start`. From that point the block works on its own. It assembles the fields, works out the 15-bit CRC, inserts stuff bits and watches its own bits on `bus_rx` as they come back from the wired-AND bus.

The attempt ends in one of four ways. It can finish cleanly. It can lose arbitration to another node. It can see a bit on the bus that differs from the one it sent. Or nobody acknowledges the frame. In every case `done` pulses for one cycle together with a `result` code. Between attempts `bus_tx` stays recessive. The block does not send error frames, does not retry and does not resynchronise to the bus.

Top module: `can_frame_tx`

## Requirements
- R1: After reset `bus_tx` is 1 and `done` is 0. A `start` pulse seen while idle captures all inputs and begins a frame. A `start` pulse during a frame has no effect on the bits being sent.
- R2: Unstuffed frame order:
  - one dominant start bit (0);
  - the identifier, MSB first;
  - three dominant bits: remote flag, format flag and reserved;
  - a 4-bit length code, MSB first;
  - the data bytes, byte 0 being `payload[63:56]`, each byte MSB first;
  - the 15-bit CRC, MSB first;
  - a recessive CRC delimiter;
  - a recessive ACK slot;
  - a recessive ACK delimiter;
  - seven recessive end bits.
- R3: The number of bytes sent, and the length code, is `byte_cnt` limited to at most 8. Payload bits beyond the bytes sent have no effect on the frame.
- R4: The CRC uses polynomial 0x4599 and starts from zero. It is computed over the unstuffed bits from the start bit through the last data bit.
- R5: After five equal bits in a row, one bit of the opposite value is inserted. Stuff bits take part in later runs. Stuffing covers the start bit through the last CRC bit, and may add one stuff bit after the last CRC bit. No stuff bits appear from the CRC delimiter onward.
- R6: Every bit lasts T = max(`bit_cycles`, 4) clock cycles. The first bit begins in the cycle after the edge that accepts `start`. `bus_rx` is sampled in cycle floor(3T/4) of each bit, counting from 0.
- R7: If the last end bit completes with no mismatch, `done` pulses one cycle later with `result` 0 (success).
- R8: If `bus_rx` is recessive at the sample point of the ACK slot, the frame stops and `done` pulses in the next cycle with `result` 3 (no acknowledge).
- R9: If a recessive non-stuff bit of the identifier or remote flag reads back dominant, the frame stops and `done` pulses in the next cycle with `result` 2 (arbitration lost).
- R10: Any other mismatch between `bus_tx` and `bus_rx` at a sample point outside the ACK slot stops the frame and gives `result` 1 (bus error) one cycle later. This includes stuff bits and the delimiter and end bits.
- R11: Each accepted frame produces exactly one single-cycle `done` pulse. `bus_tx` is 1 in that cycle and at all times outside a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request one frame (honoured only when idle) |
| frame_id | input | 11 | Identifier to send |
| payload | input | 64 | Data bytes, byte 0 in the top eight bits |
| byte_cnt | input | 4 | Requested byte count (values above 8 are treated as 8) |
| bit_cycles | input | BT_W (16) | Clock cycles per bit (values below 4 are treated as 4) |
| bus_rx | input | 1 | Bus level read back |
| bus_tx | output | 1 | Bit driven to the bus, 1 when idle |
| done | output | 1 | One-cycle end-of-attempt pulse |
| result | output | 2 | 0 success, 1 bus error, 2 arbitration lost, 3 no acknowledge |

## Verification
The bench goes after runs of equal bits. All-zero and all-one identifiers and payloads force stuff bits inside the identifier, the data and right after the CRC; a stuffer that counted only original bits, or that stopped before the final CRC bit, would shift every following bit. Byte counts of 0, 1 and 13 are used, and the unused payload bits are filled with noise. A design that ignored the clamp, or let spare bits leak into the frame, would send the wrong length code and CRC. Bit lengths of 2, 4, 6, 7 and 8 cycles test the sample point and the minimum of 4, where sampling falls on the last cycle of a bit. Dominant bits are injected into a recessive identifier bit, a data bit, the ACK delimiter and an end bit, and the ACK slot is left open. These cases show whether each failure gives the right code, in the right cycle, and whether arbitration loss is wrongly reported as a bus error or the reverse.

// File: rtl/can_tx_pkg.sv
// Package: shared constants and types for the CAN frame sender.
// Assumes base-format data frames only.
package can_tx_pkg;

    localparam int ID_W      = 11;
    localparam int DLC_W     = 4;
    localparam int CRC_W     = 15;
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
    localparam int MAX_BYTES = 8;
    localparam int EOF_BITS  = 7;
    localparam int STUFF_RUN = 5;
    localparam int IDX_W     = 7;

    // Outcome of one attempt, as seen on the result port.
    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_BUS_ERR  = 2'd1,
        RES_ARB_LOST = 2'd2,
        RES_NO_ACK   = 2'd3
    } tx_result_e;

    // Frame fields, listed in transmission order (the order is relied upon).
    typedef enum logic [3:0] {
        FLD_SOF,
        FLD_ID,
        FLD_RTR,
        FLD_IDE,
        FLD_R0,
        FLD_DLC,
        FLD_DATA,
        FLD_CRC,
        FLD_CRC_DEL,
        FLD_ACK,
        FLD_ACK_DEL,
        FLD_EOF
    } field_e;

endpackage

// File: rtl/can_tx_bit_timer.sv
// Module: bit-period counter. Counts clock cycles within one bit and gives a
// sample strobe at floor(3L/4) and an end-of-bit strobe at L-1.
// Assumes bit_len >= 4 and that it is held stable while run is high.
module can_tx_bit_timer #(
    parameter int BT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    input  logic [BT_W-1:0] bit_len,
    output logic            sample_tick,
    output logic            bit_end
);

    logic [BT_W-1:0] cnt_q;
    logic [BT_W+1:0] len_x3;
    logic [BT_W-1:0] samp_pt;

    // Sample point: three quarters of the bit, rounded down.
    always_comb begin
        len_x3  = {2'b00, bit_len} + {1'b0, bit_len, 1'b0};
        samp_pt = len_x3[BT_W+1:2];
    end

    assign bit_end     = run && (cnt_q == bit_len - 1'b1);
    assign sample_tick = run && (cnt_q == samp_pt);

    // Cycle counter, wrapping at the end of every bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            if (bit_end) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_in_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < bit_len));

endmodule

// File: rtl/can_tx_crc15.sv
// Module: 15-bit CRC register. Folds in one message bit per shift_in_en;
// during emit_en it shifts left so that the msb output walks through the CRC.
// Assumes the two enables are never high together.
module can_tx_crc15 #(
    parameter int             W    = 15,
    parameter logic [W-1:0]   POLY = 15'h4599
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_in_en,
    input  logic emit_en,
    input  logic bit_in,
    output logic msb
);

    logic [W-1:0] crc_q;
    logic         fb;

    assign fb  = bit_in ^ crc_q[W-1];
    assign msb = crc_q[W-1];

    // CRC accumulate, then shift out.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= '0;
        end else if (shift_in_en) begin
            crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (emit_en) begin
            crc_q <= {crc_q[W-2:0], 1'b0};
        end
    end

    assert_crc_modes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_in_en && emit_en));

endmodule

// File: rtl/can_tx_stuffer.sv
// Module: run-length tracker for bit stuffing. Every bit sent inside the
// stuffed zone is pushed; stuff_due rises after RUN_LEN equal bits, and the
// caller must then send stuff_val.
// Assumes the caller clears it at the start of each frame.
module can_tx_stuffer #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic push,
    input  logic bit_in,
    output logic stuff_due,
    output logic stuff_val
);

    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_q;
    logic          last_q;

    assign stuff_due = (run_q == CW'(RUN_LEN));
    assign stuff_val = ~last_q;

    // Track the length and value of the current run of equal bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else if (push) begin
            if (run_q != '0 && bit_in == last_q) run_q <= run_q + 1'b1;
            else                                 run_q <= CW'(1);
            last_q <= bit_in;
        end
    end

    assert_stuff_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && stuff_due) |-> (bit_in != last_q));

    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(RUN_LEN));

endmodule

// File: rtl/can_frame_tx.sv
// Module: CAN base-format data frame sender (top). Captures a request, walks
// the frame fields bit by bit, and compares each sent bit with the read-back
// bus level at the sample point. Stops on the first problem and reports
// exactly one outcome.
// Assumes bus_rx is already synchronised to clk. No resynchronisation is done.
module can_frame_tx
    import can_tx_pkg::*;
#(
    parameter int BT_W        = 16,
    parameter int MIN_BIT_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [10:0]     frame_id,
    input  logic [63:0]     payload,
    input  logic [3:0]      byte_cnt,
    input  logic [BT_W-1:0] bit_cycles,
    input  logic            bus_rx,
    output logic            bus_tx,
    output logic            done,
    output logic [1:0]      result
);

    localparam int PAYLOAD_W = 8 * MAX_BYTES;

    logic                 running_q;
    field_e               field_q;
    logic [IDX_W-1:0]     idx_q;
    logic [ID_W-1:0]      id_sh;
    logic [PAYLOAD_W-1:0] data_sh;
    logic [DLC_W-1:0]     dlc_q;
    logic [DLC_W-1:0]     dlc_sh;
    logic [BT_W-1:0]      bit_len_q;
    logic                 done_q;
    tx_result_e           res_q;

    logic                 start_ok;
    logic [DLC_W-1:0]     dlc_in;
    logic [BT_W-1:0]      len_in;
    logic                 sample_tick;
    logic                 bit_end;
    logic                 stuff_due;
    logic                 stuff_val;
    logic                 crc_msb;
    logic                 field_bit;
    logic                 tx_bit;
    logic                 in_arb;
    logic                 in_stuff_zone;
    logic                 abort_hit;
    tx_result_e           abort_code;
    logic                 abort_now;
    logic                 advance;
    logic                 field_step;
    logic [IDX_W-1:0]     fld_len;
    logic                 last_of_field;
    field_e               next_field;

    // Request acceptance and input clamping.
    always_comb begin
        start_ok = start && !running_q;
        dlc_in   = (byte_cnt > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : byte_cnt;
        len_in   = (bit_cycles < BT_W'(MIN_BIT_LEN)) ? BT_W'(MIN_BIT_LEN) : bit_cycles;
    end

    can_tx_bit_timer #(.BT_W(BT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (start_ok),
        .run         (running_q),
        .bit_len     (bit_len_q),
        .sample_tick (sample_tick),
        .bit_end     (bit_end)
    );

    can_tx_stuffer #(.RUN_LEN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .push      (advance && (stuff_due || in_stuff_zone)),
        .bit_in    (tx_bit),
        .stuff_due (stuff_due),
        .stuff_val (stuff_val)
    );

    can_tx_crc15 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start_ok),
        .shift_in_en (field_step && (field_q <= FLD_DATA)),
        .emit_en     (field_step && (field_q == FLD_CRC)),
        .bit_in      (field_bit),
        .msb         (crc_msb)
    );

    // Value of the current (non-stuff) field bit.
    always_comb begin
        unique case (field_q)
            FLD_ID:   field_bit = id_sh[ID_W-1];
            FLD_DLC:  field_bit = dlc_sh[DLC_W-1];
            FLD_DATA: field_bit = data_sh[PAYLOAD_W-1];
            FLD_CRC:  field_bit = crc_msb;
            FLD_SOF, FLD_RTR, FLD_IDE, FLD_R0: field_bit = 1'b0;
            default:  field_bit = 1'b1;
        endcase
    end

    // Field length and successor field.
    always_comb begin
        unique case (field_q)
            FLD_ID:   fld_len = IDX_W'(ID_W);
            FLD_DLC:  fld_len = IDX_W'(DLC_W);
            FLD_DATA: fld_len = {dlc_q, 3'b000};
            FLD_CRC:  fld_len = IDX_W'(CRC_W);
            FLD_EOF:  fld_len = IDX_W'(EOF_BITS);
            default:  fld_len = IDX_W'(1);
        endcase
        last_of_field = (idx_q == fld_len - 1'b1);
        unique case (field_q)
            FLD_SOF:     next_field = FLD_ID;
            FLD_ID:      next_field = FLD_RTR;
            FLD_RTR:     next_field = FLD_IDE;
            FLD_IDE:     next_field = FLD_R0;
            FLD_R0:      next_field = FLD_DLC;
            FLD_DLC:     next_field = (dlc_q == '0) ? FLD_CRC : FLD_DATA;
            FLD_DATA:    next_field = FLD_CRC;
            FLD_CRC:     next_field = FLD_CRC_DEL;
            FLD_CRC_DEL: next_field = FLD_ACK;
            FLD_ACK:     next_field = FLD_ACK_DEL;
            FLD_ACK_DEL: next_field = FLD_EOF;
            default:     next_field = FLD_EOF;
        endcase
    end

    // Bit on the wire, read-back check and step control.
    always_comb begin
        tx_bit        = stuff_due ? stuff_val : field_bit;
        in_arb        = (field_q == FLD_ID) || (field_q == FLD_RTR);
        in_stuff_zone = (field_q <= FLD_CRC);
        abort_hit     = 1'b0;
        abort_code    = RES_BUS_ERR;
        if (field_q == FLD_ACK && !stuff_due) begin
            if (bus_rx) begin
                abort_hit  = 1'b1;
                abort_code = RES_NO_ACK;
            end
        end else if (tx_bit != bus_rx) begin
            abort_hit  = 1'b1;
            abort_code = (tx_bit && in_arb && !stuff_due) ? RES_ARB_LOST : RES_BUS_ERR;
        end
        abort_now  = sample_tick && abort_hit;
        advance    = bit_end && !abort_now;
        field_step = advance && !stuff_due;
    end

    // Frame sequencer: start, field walk, and end of attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            field_q   <= FLD_SOF;
            idx_q     <= '0;
            done_q    <= 1'b0;
            res_q     <= RES_OK;
        end else begin
            done_q <= 1'b0;
            if (start_ok) begin
                running_q <= 1'b1;
                field_q   <= FLD_SOF;
                idx_q     <= '0;
            end else if (abort_now) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
                res_q     <= abort_code;
            end else if (field_step) begin
                if (last_of_field) begin
                    if (field_q == FLD_EOF) begin
                        running_q <= 1'b0;
                        done_q    <= 1'b1;
                        res_q     <= RES_OK;
                    end else begin
                        field_q <= next_field;
                        idx_q   <= '0;
                    end
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Captured request and the shift registers that serialise it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_sh     <= '0;
            data_sh   <= '0;
            dlc_q     <= '0;
            dlc_sh    <= '0;
            bit_len_q <= BT_W'(MIN_BIT_LEN);
        end else if (start_ok) begin
            id_sh     <= frame_id;
            data_sh   <= payload;
            dlc_q     <= dlc_in;
            dlc_sh    <= dlc_in;
            bit_len_q <= len_in;
        end else if (field_step) begin
            if (field_q == FLD_ID)   id_sh   <= {id_sh[ID_W-2:0], 1'b0};
            if (field_q == FLD_DLC)  dlc_sh  <= {dlc_sh[DLC_W-2:0], 1'b0};
            if (field_q == FLD_DATA) data_sh <= {data_sh[PAYLOAD_W-2:0], 1'b0};
        end
    end

    assign bus_tx = running_q ? tx_bit : 1'b1;
    assign done   = done_q;
    assign result = res_q;

    assert_cfg_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && $past(running_q)) |-> ($stable(dlc_q) && $stable(bit_len_q)));

    assert_ok_at_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && res_q == RES_OK) |-> (field_q == FLD_EOF));

    assert_noack_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && res_q == RES_NO_ACK) |-> (field_q == FLD_ACK));

    assert_arb_in_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && res_q == RES_ARB_LOST) |-> in_arb);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_tx_idle_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> bus_tx);

endmodule

// File: tb/test_can_frame_tx.sv
`timescale 1ns/1ps
module test_can_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [10:0] frame_id;
    logic [63:0] payload;
    logic [3:0]  byte_cnt;
    logic [15:0] bit_cycles;
    logic        bus_rx;
    logic        bus_tx;
    logic        done;
    logic [1:0]  result;
    logic        force_dom;
    logic        ack_pull;

    int total = 0;
    int bad   = 0;

    // Expected frame built by the bench
    bit exp_bits [0:199];
    int exp_len;
    int ack_pos;
    int upos [0:127];

    always #2.5 clk = ~clk;

    // wired-AND bus: other nodes may only pull it dominant
    assign bus_rx = bus_tx & ~force_dom & ~ack_pull;

    can_frame_tx i_can_frame_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_id(frame_id),
        .payload(payload), .byte_cnt(byte_cnt), .bit_cycles(bit_cycles),
        .bus_rx(bus_rx), .bus_tx(bus_tx), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Build the expected stuffed bit stream from the requirements.
    task automatic build(input logic [10:0] id, input logic [63:0] pl, input int cnt);
        bit u [0:127];
        int ul = 0;
        int n;
        int o = 0;
        int run = 0;
        bit last = 1'b0;
        bit nx;
        logic [14:0] c = '0;
        n = (cnt > 8) ? 8 : cnt;
        u[ul] = 1'b0; ul++;
        for (int i = 10; i >= 0; i--) begin u[ul] = id[i]; ul++; end
        for (int i = 0; i < 3; i++) begin u[ul] = 1'b0; ul++; end
        for (int i = 3; i >= 0; i--) begin u[ul] = n[i]; ul++; end
        for (int b = 0; b < n * 8; b++) begin u[ul] = pl[63 - b]; ul++; end
        for (int i = 0; i < ul; i++) begin
            nx = u[i] ^ c[14];
            c  = {c[13:0], 1'b0};
            if (nx) c = c ^ 15'h4599;
        end
        for (int i = 14; i >= 0; i--) begin u[ul] = c[i]; ul++; end
        for (int i = 0; i < ul; i++) begin
            exp_bits[o] = u[i];
            upos[i] = o;
            o++;
            if (run > 0 && u[i] == last) run++;
            else run = 1;
            last = u[i];
            if (run == 5) begin
                exp_bits[o] = ~last;
                o++;
                last = ~last;
                run = 1;
            end
        end
        exp_bits[o] = 1'b1; o++;
        ack_pos = o;
        for (int i = 0; i < 9; i++) begin exp_bits[o] = 1'b1; o++; end
        exp_len = o;
    endtask

    // Send one frame and check bits, outcome and its timing.
    // force_at: stuffed bit index pulled dominant (-1 none); stop_bit: bit
    // where the attempt must end early (-1 for a full frame).
    task automatic run_frame(input logic [10:0] id, input logic [63:0] pl,
                             input int cnt, input int bt_in, input int force_at,
                             input bit ack_on, input int exp_res, input int stop_bit,
                             input int mid_start, input string tag);
        int bt;
        int samp;
        int n_done;
        int mism = 0;
        int first_bad = -1;
        int early = 0;
        build(id, pl, cnt);
        bt     = (bt_in < 4) ? 4 : bt_in;
        samp   = (3 * bt) / 4;
        n_done = (stop_bit < 0) ? exp_len * bt : stop_bit * bt + samp + 1;
        @(negedge clk);
        frame_id = id; payload = pl; byte_cnt = 4'(cnt); bit_cycles = 16'(bt_in);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= n_done; n++) begin
            force_dom = (n / bt == force_at);
            ack_pull  = ack_on && (n / bt == ack_pos);
            if (n == mid_start) begin
                frame_id = ~id; byte_cnt = 4'd0; bit_cycles = 16'd5; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (n < n_done) begin
                if (done) early++;
                if (n % bt == bt / 2 && bus_tx != exp_bits[n / bt]) begin
                    mism++;
                    if (first_bad < 0) first_bad = n / bt;
                end
            end else begin
                chk(done == 1'b1 && early == 0, tag, "done pulse timing", int'(done), 1);
                chk(int'(result) == exp_res, tag, "result code", int'(result), exp_res);
                chk(bus_tx == 1'b1, "R11", "tx recessive at done", int'(bus_tx), 1);
            end
            if (n < n_done) @(negedge clk);
        end
        chk(mism == 0, tag, "bit stream mismatch at bit", first_bad, -1);
        force_dom = 1'b0;
        ack_pull  = 1'b0;
        start     = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R11", "done is a single pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; force_dom = 1'b0; ack_pull = 1'b0;
        frame_id = '0; payload = '0; byte_cnt = '0; bit_cycles = 16'd8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_tx == 1'b1, "R1", "tx after reset", int'(bus_tx), 1);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    endtask

    task automatic t_basic();     // R2 R4 R6 R7
        run_frame(11'h123, 64'hA5C3_0000_0000_0000, 2, 8, -1, 1'b1, 0, -1, -1, "R2");
    endtask

    task automatic t_stuff();     // R5: long equal runs in every stuffed field
        run_frame(11'h000, 64'h0, 8, 8, -1, 1'b1, 0, -1, -1, "R5");
        run_frame(11'h7FF, 64'hFFFF_FFFF_FFFF_FFFF, 8, 6, -1, 1'b1, 0, -1, -1, "R5");
    endtask

    task automatic t_counts();    // R3: zero, partial with noise, clamp
        run_frame(11'h2B4, 64'h1234_5678_9ABC_DEF0, 0, 8, -1, 1'b1, 0, -1, -1, "R3");
        run_frame(11'h2B4, 64'h5E37_9AC1_44D2_0F6B, 1, 8, -1, 1'b1, 0, -1, -1, "R3");
        run_frame(11'h055, 64'h0123_4567_89AB_CDEF, 13, 8, -1, 1'b1, 0, -1, -1, "R3");
    endtask

    task automatic t_timing();    // R6: floor of 4, odd length, tight length
        run_frame(11'h3C1, 64'hF00F_0000_0000_0000, 2, 2, -1, 1'b1, 0, -1, -1, "R6");
        run_frame(11'h3C1, 64'hF00F_0000_0000_0000, 2, 7, -1, 1'b1, 0, -1, -1, "R6");
    endtask

    task automatic t_noack();     // R8
        build(11'h111, 64'hCAFE_0000_0000_0000, 2);
        run_frame(11'h111, 64'hCAFE_0000_0000_0000, 2, 8, -1, 1'b0, 3, ack_pos, -1, "R8");
    endtask

    task automatic t_arb();       // R9: identifier bit 7 (value 1) pulled dominant
        int fa;
        build(11'h4A5, 64'h0, 1);
        fa = upos[1 + 3];
        run_frame(11'h4A5, 64'h0, 1, 8, fa, 1'b1, 2, fa, -1, "R9");
        build(11'h4A5, 64'h0, 1);
        fa = upos[1 + 3];
        run_frame(11'h4A5, 64'h0, 1, 4, fa, 1'b1, 2, fa, -1, "R9");
    endtask

    task automatic t_err();       // R10: data bit, ACK delimiter, end bit
        int fa;
        build(11'h0F0, 64'h8000_0000_0000_0000, 1);
        fa = upos[19];
        run_frame(11'h0F0, 64'h8000_0000_0000_0000, 1, 8, fa, 1'b1, 1, fa, -1, "R10");
        build(11'h0F0, 64'h8000_0000_0000_0000, 1);
        fa = ack_pos + 1;
        run_frame(11'h0F0, 64'h8000_0000_0000_0000, 1, 8, fa, 1'b1, 1, fa, -1, "R10");
        build(11'h0F0, 64'h8000_0000_0000_0000, 1);
        fa = ack_pos + 5;
        run_frame(11'h0F0, 64'h8000_0000_0000_0000, 1, 6, fa, 1'b1, 1, fa, -1, "R10");
    endtask

    task automatic t_busy_start(); // R1: second start mid-frame ignored
        run_frame(11'h6D2, 64'h7777_1111_0000_0000, 4, 8, -1, 1'b1, 0, -1, 160, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_stuff();
        t_counts();
        t_timing();
        t_noack();
        t_arb();
        t_err();
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule